// File: doc/BRIEF.md
# Pulse Accumulator with Interrupt Flags

This block counts edges on an external input pin with an 8-bit accumulator. Software reaches it over a simple byte-wide register bus. The pin passes through a two-stage synchronizer. A configuration bit then picks whether rising or falling edges are counted, and a second configuration bit turns accumulation on or off. Software can read the count at any time and can load a new value.

Two sticky event flags record what has happened. One flag marks a wrap of the count from 0xFF to 0x00. The other marks every counted edge. Each flag is cleared by writing a one to its bit. An interrupt-enable register holds one enable per flag, and the single request output is the OR of every enable-and-flag pair. The enables affect only the request output, so software can also poll the flags with interrupts off. The mask register and the top two flag bits also hold timer and real-time bits; this block only stores them.

Top module: `pulse_acc`

## Requirements
- R1: After reset, the registers at 0x24, 0x25, 0x26 and 0x27 all read 0x00, and irq_o is 0.
- R2: When the config register 0x26 has bit 0 (enable) at 1, each edge of pin_i adds one to the count at 0x27. The edge is rising when bit 1 of 0x26 is 0 and falling when it is 1. The count is updated within three clock edges of the pin change.
- R3: Flag bit 5 of register 0x25 is set when a counted edge takes the count from 0xFF to 0x00, and at no other time.
- R4: Flag bit 4 of register 0x25 is set by every counted edge.
- R5: Flag bits 5 and 4 stay at 1 until software writes a one to that bit of 0x25. Writing a zero leaves the flag unchanged. Bits 3:0 of 0x25 always read 0.
- R6: If a counted edge sets a flag in the same cycle as a write of one to that flag's bit, the flag ends at 1.
- R7: A write to 0x27 loads the count and never sets flag bit 5. If a counted edge falls in the same cycle, the written value wins.
- R8: While bit 0 of 0x26 is 0, edges on pin_i neither change the count nor set any flag.
- R9: Writing the enable register 0x24 never changes any flag in 0x25.
- R10: irq_o is 1 exactly when, for some bit n in 7:4, bit n of 0x24 and bit n of 0x25 are both 1.
- R11: In register 0x24, bits 7:4 and 1:0 can be written and read back, and bits 3:2 read 0. In register 0x25, bits 7:6 are plain storage that load whatever value is written to them.
- R12: In register 0x26, only bits 1:0 are kept and the other bits read 0. Any other address reads 0x00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous accumulator input |
| bus_addr_i | input | 8 | Register offset |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Software writes can land in the same cycle as a counted edge in two ways. A load of the count can meet an increment, and a write-one-to-clear of a flag can meet that flag's set event. The bench changes the pin and then asserts the bus write on the second falling clock edge after the change, which is exactly the cycle in which the synchronized edge acts. For the load case, it judges the result by the count read back and the state of the overflow flag. For the clear case, it judges by whether the flag survives the clear.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 8;

  typedef logic [DATA_W-1:0] byte_t;

  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_FLAG = 8'h25;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 8'h26;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h27;

  localparam int unsigned BIT_EDG = 4;
  localparam int unsigned BIT_OVF = 5;
  localparam int unsigned N_EVT   = 2;  // hardware-set flags at BIT_EDG upward
  localparam int unsigned N_REQ   = 4;  // enable/flag pairs at bits 7:4

  localparam byte_t MASK_RW = 8'hF3;

  typedef struct packed {
    logic fall;  // 1: count falling edges
    logic en;
  } acc_cfg_t;
endpackage

// File: rtl/pacc_edge.sv
module pacc_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_i,
  output logic edge_o
);
  localparam int unsigned SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic            cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SH_W-2:0], pin_i};
  end

  assign cur    = sh_q[SYNC_STAGES-1];
  assign prev   = sh_q[SYNC_STAGES];
  assign edge_o = fall_i ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // load beats increment, so a load cycle never reports a wrap
  assign wrap_o = inc_i & ~load_i & (cnt_q == TOP);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pacc_regs.sv
module pacc_regs
  import pacc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  byte_t             wdata_i,
  input  byte_t             cnt_i,
  input  logic [N_EVT-1:0]  evt_set_i,
  output byte_t             mask_o,
  output byte_t             flag_o,
  output acc_cfg_t          cfg_o,
  output logic              cnt_load_o,
  output byte_t             rdata_o
);
  logic wr_mask, wr_flag, wr_cfg;
  byte_t mask_q;
  logic [1:0] hi_q;
  logic [N_EVT-1:0] evt_q, evt_d;
  acc_cfg_t cfg_q;

  assign wr_mask    = we_i && (addr_i == OFF_MASK);
  assign wr_flag    = we_i && (addr_i == OFF_FLAG);
  assign wr_cfg     = we_i && (addr_i == OFF_CFG);
  assign cnt_load_o = we_i && (addr_i == OFF_CNT);

  // set wins over write-one-to-clear
  always_comb begin
    for (int i = 0; i < N_EVT; i++)
      evt_d[i] = evt_set_i[i] | (evt_q[i] & ~(wr_flag & wdata_i[BIT_EDG+i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      hi_q   <= '0;
      evt_q  <= '0;
      cfg_q  <= '0;
    end else begin
      evt_q <= evt_d;
      if (wr_mask) mask_q <= wdata_i & MASK_RW;
      if (wr_flag) hi_q   <= wdata_i[7:6];
      if (wr_cfg)  cfg_q  <= wdata_i[1:0];
    end
  end

  assign mask_o = mask_q;
  assign flag_o = {hi_q, evt_q, 4'b0000};
  assign cfg_o  = cfg_q;

  always_comb begin
    unique case (addr_i)
      OFF_MASK: rdata_o = mask_q;
      OFF_FLAG: rdata_o = flag_o;
      OFF_CFG:  rdata_o = {6'b0, cfg_q};
      OFF_CNT:  rdata_o = cnt_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
  import pacc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pin_i,
  input  logic [7:0]  bus_addr_i,
  input  logic        bus_we_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  output logic        irq_o
);
  acc_cfg_t cfg_w;
  byte_t    mask_w, flag_w, cnt_w;
  logic     edge_w, inc_w, wrap_w, load_w;
  logic [N_REQ-1:0] req_w;

  pacc_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .fall_i (cfg_w.fall),
    .edge_o (edge_w)
  );

  assign inc_w = edge_w & cfg_w.en;

  pacc_counter #(.W(DATA_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc_w),
    .load_i     (load_w),
    .load_val_i (bus_wdata_i),
    .cnt_o      (cnt_w),
    .wrap_o     (wrap_w)
  );

  pacc_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (bus_addr_i),
    .we_i       (bus_we_i),
    .wdata_i    (bus_wdata_i),
    .cnt_i      (cnt_w),
    .evt_set_i  ({wrap_w, inc_w}),
    .mask_o     (mask_w),
    .flag_o     (flag_w),
    .cfg_o      (cfg_w),
    .cnt_load_o (load_w),
    .rdata_o    (bus_rdata_o)
  );

  for (genvar g = 0; g < N_REQ; g++) begin : g_req
    assign req_w[g] = mask_w[BIT_EDG+g] & flag_w[BIT_EDG+g];
  end

  assign irq_o = |req_w;
endmodule

// File: rtl/pulse_acc_chk.sv
module pulse_acc_chk
  import pacc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] bus_addr_i,
  input logic       bus_we_i,
  input logic [7:0] bus_wdata_i,
  input logic       irq_o,
  input logic [7:0] cnt_i,
  input logic [7:0] flag_i,
  input logic [7:0] mask_i,
  input logic       en_i,
  input logic       edge_i
);
  logic cnt_wr, flag_wr;
  assign cnt_wr  = bus_we_i && (bus_addr_i == OFF_CNT);
  assign flag_wr = bus_we_i && (bus_addr_i == OFF_FLAG);

  a_r7_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (cnt_i == $past(bus_wdata_i)));

  a_r8_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_wr) |=> $stable(cnt_i));

  a_r6_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && en_i) |=> flag_i[BIT_EDG]);

  a_r5_edge_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i[BIT_EDG] && !(flag_wr && bus_wdata_i[BIT_EDG])) |=> flag_i[BIT_EDG]);

  a_r3_wrap_sets_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == 8'hFF && edge_i && en_i && !cnt_wr) |=> flag_i[BIT_OVF]);

  a_r10_irq_on_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i[BIT_OVF] && mask_i[BIT_OVF]) |-> irq_o);

  a_r5_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i[3:0] == 4'b0);
endmodule

bind pulse_acc pulse_acc_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_we_i    (bus_we_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .cnt_i       (cnt_w),
  .flag_i      (flag_w),
  .mask_i      (mask_w),
  .en_i        (cfg_w.en),
  .edge_i      (edge_w)
);

// File: tb/test_pulse_acc.sv
module test_pulse_acc;
  localparam time CLK_P = 10ns;
  localparam logic [7:0] A_MASK = 8'h24, A_FLAG = 8'h25, A_CFG = 8'h26, A_CNT = 8'h27;

  logic clk = 0, rst_n = 0, pin = 0, we = 0, irq;
  logic [7:0] addr = 0, wdata = 0, rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_cnt = 0, m_mask = 0;
  logic [1:0] m_cfg = 0, m_hi = 0;
  logic m_ovf = 0, m_edg = 0;

  pulse_acc i_pulse_acc (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] exp_flag();
    return {m_hi, m_ovf, m_edg, 4'b0};
  endfunction

  function automatic logic exp_irq();
    return |(m_mask[7:4] & exp_flag() >> 0 & 8'hF0) != 0 ? 1'b1 : 1'b0;
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    case (a)
      A_MASK: return m_mask;
      A_FLAG: return exp_flag();
      A_CFG:  return {6'b0, m_cfg};
      A_CNT:  return m_cnt;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(string tag, logic [7:0] a);
    @(negedge clk); addr = a; #1;
    check(tag, rdata, exp_rd(a));
  endtask

  task automatic irq_chk(string tag);
    @(negedge clk); #1;
    check(tag, {7'b0, irq}, {7'b0, |(m_mask[7:4] & exp_flag()[7:4])});
  endtask

  // bus write plus reference update
  task automatic model_wr(logic [7:0] a, logic [7:0] d);
    case (a)
      A_MASK: m_mask = d & 8'hF3;
      A_FLAG: begin
        m_hi = d[7:6];
        if (d[5]) m_ovf = 0;
        if (d[4]) m_edg = 0;
      end
      A_CFG: m_cfg = d[1:0];
      A_CNT: m_cnt = d;
      default: ;
    endcase
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
    model_wr(a, d);
  endtask

  function automatic bit counts(logic lvl);
    return m_cfg[0] && (m_cfg[1] ? !lvl : lvl);
  endfunction

  task automatic model_edge();
    m_edg = 1;
    if (m_cnt == 8'hFF) m_ovf = 1;
    m_cnt = m_cnt + 1;
  endtask

  task automatic toggle();
    @(negedge clk); pin = ~pin;
    repeat (4) @(negedge clk);
    if (counts(pin)) model_edge();
  endtask

  // pin change and bus write reach the registers in the same cycle
  task automatic collide(logic [7:0] a, logic [7:0] d);
    @(negedge clk); pin = ~pin;
    @(negedge clk);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd_chk("R1 mask", A_MASK); rd_chk("R1 flag", A_FLAG);
    rd_chk("R1 cfg", A_CFG);   rd_chk("R1 cnt", A_CNT);
    irq_chk("R1 irq");

    // R8: disabled, edges ignored
    toggle(); toggle();
    rd_chk("R8 cnt", A_CNT); rd_chk("R8 flag", A_FLAG);

    // R2, R4: rising
    wr(A_CFG, 8'h01);
    toggle(); rd_chk("R2 rise cnt", A_CNT); rd_chk("R4 edge flag", A_FLAG);
    toggle(); rd_chk("R2 fall ignored", A_CNT);
    // falling
    wr(A_CFG, 8'h03);
    toggle(); toggle(); rd_chk("R2 falling cnt", A_CNT);

    // R12, R11
    wr(A_CFG, 8'hFD); rd_chk("R12 cfg bits", A_CFG);
    wr(8'h30, 8'hAA); rd_chk("R12 unmapped", 8'h30);
    rd_chk("R12 state kept", A_CNT);
    wr(A_MASK, 8'hFF); rd_chk("R11 mask bits", A_MASK);
    wr(A_MASK, 8'h00);
    wr(A_FLAG, 8'hC0); rd_chk("R11 hi storage", A_FLAG);

    // R5
    wr(A_FLAG, 8'h0F); rd_chk("R5 zero writes keep", A_FLAG);
    wr(A_FLAG, 8'h10); rd_chk("R5 clear edge", A_FLAG);

    // R7, R3
    wr(A_CFG, 8'h01);
    wr(A_CNT, 8'hFF); rd_chk("R7 load no ovf", A_FLAG);
    toggle(); if (pin == 0) toggle();
    rd_chk("R3 wrap cnt", A_CNT); rd_chk("R3 ovf set", A_FLAG);

    // R9, R10
    wr(A_MASK, 8'h20); irq_chk("R10 ovf irq");
    wr(A_MASK, 8'h00); irq_chk("R10 irq off"); rd_chk("R9 flags kept", A_FLAG);
    wr(A_MASK, 8'h10); irq_chk("R10 edge irq");

    // R6: clear meets set, pin is high so go low then collide on rise
    wr(A_CFG, 8'h01);
    toggle();
    wr(A_FLAG, 8'h30); rd_chk("R6 pre clear", A_FLAG);
    collide(A_FLAG, 8'h10); model_wr(A_FLAG, 8'h10); model_edge();
    rd_chk("R6 edge flag survives", A_FLAG);

    // R7: load meets increment
    toggle();
    collide(A_CNT, 8'h42); model_wr(A_CNT, 8'h42);
    rd_chk("R7 load wins", A_CNT);

    // random phase
    for (int i = 0; i < 400; i++) begin
      automatic int op = $urandom_range(0, 9);
      automatic logic [7:0] d = 8'($urandom);
      automatic logic [7:0] a;
      case (op)
        0, 1, 2, 3: toggle();
        4: wr(A_CNT, ($urandom_range(0, 3) == 0) ? 8'hFE : d);
        5: wr(A_MASK, d);
        6: wr(A_FLAG, d);
        7: wr(A_CFG, d | 8'h01);
        8: wr(A_CFG, d);
        default: begin
          a = 8'h24 + 8'($urandom_range(0, 3));
          rd_chk("R2 R3 R4 R5 random read", a);
          irq_chk("R10 random irq");
        end
      endcase
    end
    rd_chk("R2 final cnt", A_CNT); rd_chk("R5 final flag", A_FLAG);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule